// File: doc/BRIEF.md
# Acquisition Trigger Control Unit

This unit merges three trigger sources into one acquisition trigger for a data-capture path: a software trigger taken from a control word, a cascade trigger pulse arriving from a neighbouring capture block, and a hardware trigger pulse from the timing logic. Each source is accepted under its own rules, and the accepted events are ORed into a single-cycle pulse. That pulse also advances a 32-bit event counter.

The control word is written through a plain write-enable and data port and is held in a register. The software trigger, the arm request and the status clear all act on the 0-to-1 transition of their control bits. A hardware trigger is accepted only while the unit is armed, or while automatic re-arming is on. A separate freeze request to the capture buffers comes either from software or from an external hardware request that has its own enable. The status word reports which sources have fired since the last clear, whether the hardware trigger is armed, and whether a freeze has occurred.

Top module: `acq_trig_unit`

## Requirements
- R1: After reset, trig_o and freeze_o are 0, status_o is 0 and trig_count_o is 0.
- R2: A software trigger is produced when control bit 0 goes from 0 to 1. A write that leaves bit 0 at 1 produces no trigger.
- R3: A 0-to-1 transition of control bit 3 sets status bit 3 (armed). While control bit 2 is 0, an accepted hardware trigger clears status bit 3.
- R4: A rising edge on hw_trig_i is ignored (no trig_o, no count) when status bit 3 is 0 and control bit 2 is 0.
- R5: While control bit 2 (auto re-arm) is 1, every rising edge on hw_trig_i is accepted without re-arming.
- R6: A rising edge on casc_trig_i is accepted only while control bit 1 is 1.
- R7: Status bits 0 (software), 1 (cascade), 2 (hardware), 4 (combined) and 5 (freeze) are set by their event and stay set until a 0-to-1 transition of control bit 4. If an event and a clear happen in the same cycle, the event wins.
- R8: trig_o is a one-cycle pulse on the clock edge after an accepted event, and is the OR of all accepted sources. Coincident events give one pulse.
- R9: trig_count_o increments by exactly one for each cycle in which trig_o is high, holds its value otherwise, and wraps at 2^32.
- R10: freeze_o is high one edge after control bit 5 is 1, or after hw_freeze_i is 1 while control bit 6 is 1. Status bit 5 sets together with freeze_o.
- R11: A hardware or cascade input held high for many cycles counts as one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control word write enable |
| ctrl_wdata_i | input | 7 | Control word write data |
| hw_trig_i | input | 1 | Hardware trigger, synchronous to clk_i |
| casc_trig_i | input | 1 | Cascade trigger, synchronous to clk_i |
| hw_freeze_i | input | 1 | External freeze request |
| trig_o | output | 1 | Combined acquisition trigger pulse |
| freeze_o | output | 1 | Freeze request to the capture buffers |
| status_o | output | 6 | Sticky source flags, armed flag, freeze flag |
| trig_count_o | output | 32 | Count of accepted triggers |

## Verification
On every cycle the assertions check that the counter moves exactly with trig_o, that trig_o and freeze_o are always mirrored in their sticky status bits, and that the armed flag and the sticky combined flag change only in response to the matching control write two edges earlier. The bench scenarios cover what needs history to observe: that held-high levels and repeated writes of a 1 do not retrigger, that unarmed and disabled sources are ignored, that auto re-arm accepts back-to-back pulses, and that coincident sources give one count.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;
  localparam int CTRL_W = 7;
  localparam int C_SW       = 0;
  localparam int C_CASC_EN  = 1;
  localparam int C_AUTO     = 2;
  localparam int C_ARM      = 3;
  localparam int C_CLR      = 4;
  localparam int C_SWFRZ    = 5;
  localparam int C_HWFRZ_EN = 6;

  localparam int STAT_W   = 6;
  localparam int ST_SW    = 0;
  localparam int ST_CASC  = 1;
  localparam int ST_HW    = 2;
  localparam int ST_ARMED = 3;
  localparam int ST_COMB  = 4;
  localparam int ST_FRZ   = 5;

  // sticky flag slots inside the flag bank
  localparam int NFLAG  = 5;
  localparam int F_SW   = 0;
  localparam int F_CASC = 1;
  localparam int F_HW   = 2;
  localparam int F_COMB = 3;
  localparam int F_FRZ  = 4;
endpackage

// File: rtl/atu_rise_det.sv
module atu_rise_det #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= '0;
    else         d_q <= d_i;
  end

  assign rise_o = d_i & ~d_q;
endmodule

// File: rtl/atu_sticky_bank.sv
module atu_sticky_bank #(
  parameter int N = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;  // set beats clear
      else if (clr_i)    flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/atu_counter.sv
module atu_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    count_o <= '0;
    else if (inc_i) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/acq_trig_unit.sv
module acq_trig_unit
  import acq_trig_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              hw_trig_i,
  input  logic              casc_trig_i,
  input  logic              hw_freeze_i,
  output logic              trig_o,
  output logic              freeze_o,
  output logic [STAT_W-1:0] status_o,
  output logic [CNT_W-1:0]  trig_count_o
);
  localparam int E_SW  = 0;
  localparam int E_ARM = 1;
  localparam int E_CLR = 2;
  localparam int I_HW   = 0;
  localparam int I_CASC = 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [2:0]        ctrl_edge_src, ctrl_rise;
  logic [1:0]        in_rise;
  logic              armed_q, trig_q, frz_q;
  logic              sw_acc, casc_acc, hw_acc, any_acc, frz_req;
  logic [NFLAG-1:0]  flag_set, flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
  end

  assign ctrl_edge_src = {ctrl_q[C_CLR], ctrl_q[C_ARM], ctrl_q[C_SW]};

  atu_rise_det #(.W(3)) u_ctrl_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ctrl_edge_src),
    .rise_o (ctrl_rise)
  );

  atu_rise_det #(.W(2)) u_in_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({casc_trig_i, hw_trig_i}),
    .rise_o (in_rise)
  );

  assign sw_acc   = ctrl_rise[E_SW];
  assign casc_acc = in_rise[I_CASC] & ctrl_q[C_CASC_EN];
  assign hw_acc   = in_rise[I_HW] & (armed_q | ctrl_q[C_AUTO]);
  assign any_acc  = sw_acc | casc_acc | hw_acc;
  assign frz_req  = ctrl_q[C_SWFRZ] | (hw_freeze_i & ctrl_q[C_HWFRZ_EN]);

  // arm request wins over the disarm that an accepted trigger causes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           armed_q <= 1'b0;
    else if (ctrl_rise[E_ARM])             armed_q <= 1'b1;
    else if (hw_acc && !ctrl_q[C_AUTO])    armed_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      frz_q  <= 1'b0;
    end else begin
      trig_q <= any_acc;
      frz_q  <= frz_req;
    end
  end

  always_comb begin
    flag_set         = '0;
    flag_set[F_SW]   = sw_acc;
    flag_set[F_CASC] = casc_acc;
    flag_set[F_HW]   = hw_acc;
    flag_set[F_COMB] = any_acc;
    flag_set[F_FRZ]  = frz_req;
  end

  atu_sticky_bank #(.N(NFLAG)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (ctrl_rise[E_CLR]),
    .flag_o (flags)
  );

  atu_counter #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (any_acc),
    .count_o (trig_count_o)
  );

  always_comb begin
    status_o           = '0;
    status_o[ST_SW]    = flags[F_SW];
    status_o[ST_CASC]  = flags[F_CASC];
    status_o[ST_HW]    = flags[F_HW];
    status_o[ST_ARMED] = armed_q;
    status_o[ST_COMB]  = flags[F_COMB];
    status_o[ST_FRZ]   = flags[F_FRZ];
  end

  assign trig_o   = trig_q;
  assign freeze_o = frz_q;
endmodule

// File: rtl/acq_trig_unit_chk.sv
module acq_trig_unit_chk
  import acq_trig_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic [CTRL_W-1:0] ctrl_wdata_i,
  input logic              trig_o,
  input logic              freeze_o,
  input logic [STAT_W-1:0] status_o,
  input logic [CNT_W-1:0]  trig_count_o
);
  assert_count_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> trig_count_o == $past(trig_count_o) + 1'b1);

  assert_count_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_o |-> $stable(trig_count_o));

  assert_comb_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> status_o[ST_COMB]);

  assert_freeze_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_o |-> status_o[ST_FRZ]);

  assert_clear_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[ST_COMB]) |-> $past(ctrl_we_i && ctrl_wdata_i[C_CLR], 2));

  assert_arm_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[ST_ARMED]) |-> $past(ctrl_we_i && ctrl_wdata_i[C_ARM], 2));
endmodule

bind acq_trig_unit acq_trig_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_we_i    (ctrl_we_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .trig_o       (trig_o),
  .freeze_o     (freeze_o),
  .status_o     (status_o),
  .trig_count_o (trig_count_o)
);

// File: tb/acq_trig_unit_test.sv
`timescale 1ns/1ps
module acq_trig_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [6:0]  ctrl_wdata_i = '0;
  logic        hw_trig_i = 1'b0;
  logic        casc_trig_i = 1'b0;
  logic        hw_freeze_i = 1'b0;
  logic        trig_o, freeze_o;
  logic [5:0]  status_o;
  logic [31:0] trig_count_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  acq_trig_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
    .hw_trig_i(hw_trig_i), .casc_trig_i(casc_trig_i), .hw_freeze_i(hw_freeze_i),
    .trig_o(trig_o), .freeze_o(freeze_o), .status_o(status_o), .trig_count_o(trig_count_o)
  );

  // behavioural reference
  bit [6:0]    m_ctrl, m_ctrl_prev;
  bit          m_hw_prev, m_casc_prev, m_armed, m_trig, m_frz;
  bit          f_sw, f_casc, f_hw, f_comb, f_frz;
  bit [31:0]   m_cnt;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl = 0; m_ctrl_prev = 0; m_hw_prev = 0; m_casc_prev = 0; m_armed = 0;
      m_trig = 0; m_frz = 0; f_sw = 0; f_casc = 0; f_hw = 0; f_comb = 0; f_frz = 0; m_cnt = 0;
    end else begin
      bit sw_ev, arm_ev, clr_ev, hw_ev, casc_ev, any_ev, frz_ev;
      sw_ev   = m_ctrl[0] && !m_ctrl_prev[0];
      arm_ev  = m_ctrl[3] && !m_ctrl_prev[3];
      clr_ev  = m_ctrl[4] && !m_ctrl_prev[4];
      casc_ev = casc_trig_i && !m_casc_prev && m_ctrl[1];
      hw_ev   = hw_trig_i && !m_hw_prev && (m_armed || m_ctrl[2]);
      any_ev  = sw_ev || casc_ev || hw_ev;
      frz_ev  = m_ctrl[5] || (hw_freeze_i && m_ctrl[6]);
      if (clr_ev) begin f_sw = 0; f_casc = 0; f_hw = 0; f_comb = 0; f_frz = 0; end
      if (sw_ev) f_sw = 1;
      if (casc_ev) f_casc = 1;
      if (hw_ev) f_hw = 1;
      if (any_ev) f_comb = 1;
      if (frz_ev) f_frz = 1;
      if (hw_ev && !m_ctrl[2]) m_armed = 0;
      if (arm_ev) m_armed = 1;
      if (any_ev) m_cnt = m_cnt + 1;
      m_trig = any_ev;
      m_frz = frz_ev;
      m_hw_prev = hw_trig_i;
      m_casc_prev = casc_trig_i;
      m_ctrl_prev = m_ctrl;
      if (ctrl_we_i) m_ctrl = ctrl_wdata_i;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R8 trig_o", {31'd0, trig_o}, {31'd0, m_trig});
      chk("R10 freeze_o", {31'd0, freeze_o}, {31'd0, m_frz});
      chk("R7 status_o", {26'd0, status_o},
          {26'd0, f_frz, f_comb, m_armed, f_hw, f_casc, f_sw});
      chk("R9 trig_count_o", trig_count_o, m_cnt);
    end
  end

  task automatic wr(logic [6:0] v);
    @(negedge clk_i); ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk_i); ctrl_we_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic pulse_hw(int len);
    @(negedge clk_i); hw_trig_i = 1'b1;
    repeat (len) @(negedge clk_i);
    hw_trig_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic pulse_casc();
    @(negedge clk_i); casc_trig_i = 1'b1;
    @(negedge clk_i); casc_trig_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 count in reset", trig_count_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 status after reset", {26'd0, status_o}, 32'd0);
    chk("R1 trig after reset", {31'd0, trig_o}, 32'd0);
    // R2: software edge, repeated 1 does not retrigger
    wr(7'h01);
    chk("R2 sw trigger", trig_count_o, 32'd1);
    wr(7'h01);
    chk("R2 held bit no retrigger", trig_count_o, 32'd1);
    wr(7'h00); wr(7'h01);
    chk("R2 second sw trigger", trig_count_o, 32'd2);
    wr(7'h00);
    // R4: unarmed hardware ignored
    pulse_hw(1);
    chk("R4 unarmed hw ignored", trig_count_o, 32'd2);
    // R3: arm, accept, disarm
    wr(7'h08);
    chk("R3 armed flag set", {31'd0, status_o[3]}, 32'd1);
    pulse_hw(1);
    chk("R3 armed hw accepted", trig_count_o, 32'd3);
    chk("R3 armed flag cleared", {31'd0, status_o[3]}, 32'd0);
    pulse_hw(1);
    chk("R4 disarmed hw ignored", trig_count_o, 32'd3);
    // R5: auto re-arm
    wr(7'h04);
    pulse_hw(1); pulse_hw(1);
    chk("R5 auto rearm two pulses", trig_count_o, 32'd5);
    // R11: held level counts once
    pulse_hw(6);
    chk("R11 held hw counts once", trig_count_o, 32'd6);
    // R6: cascade enable
    wr(7'h00);
    pulse_casc();
    chk("R6 cascade disabled ignored", trig_count_o, 32'd6);
    wr(7'h02);
    pulse_casc();
    chk("R6 cascade enabled", trig_count_o, 32'd7);
    chk("R7 sticky flags held", {26'd0, status_o}, 32'h17);
    // R7: clear
    wr(7'h12);
    chk("R7 clear status", {26'd0, status_o}, 32'd0);
    // R8: coincident sources give one count
    wr(7'h06);
    @(negedge clk_i); hw_trig_i = 1'b1; casc_trig_i = 1'b1;
    @(negedge clk_i); hw_trig_i = 1'b0; casc_trig_i = 1'b0;
    chk("R8 coincident single pulse", {31'd0, trig_o}, 32'd1);
    @(negedge clk_i);
    chk("R8 pulse one cycle", {31'd0, trig_o}, 32'd0);
    chk("R8 coincident one count", trig_count_o, 32'd8);
    // R10: freeze paths
    wr(7'h20);
    chk("R10 sw freeze", {31'd0, freeze_o}, 32'd1);
    wr(7'h00);
    chk("R10 freeze drops", {31'd0, freeze_o}, 32'd0);
    chk("R10 freeze flag sticky", {31'd0, status_o[5]}, 32'd1);
    wr(7'h10); wr(7'h00);
    @(negedge clk_i); hw_freeze_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R10 hw freeze masked", {31'd0, freeze_o}, 32'd0);
    wr(7'h40);
    chk("R10 hw freeze enabled", {31'd0, freeze_o}, 32'd1);
    hw_freeze_i = 1'b0;
    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule